// File: doc/BRIEF.md
# Accumulator Operate Microinstruction Unit

This unit carries out the "operate" class of instructions (top three instruction bits all ones) of a small 12-bit word machine. It holds a 12-bit accumulator and a 1-bit link register. Each instruction bit turns one micro-operation on, and one instruction may turn on several. Group 1 instructions (instruction bit 8 low) clear, complement, increment and rotate the accumulator and link. Within one instruction these steps always run in the same order. Group 2 instructions (bit 8 high, bit 0 low) test the accumulator sign and request a skip of the next instruction, and they can stop the machine.

Bits are numbered here as vector indices: `instr[11]` is the most significant bit. Each instruction presented with `instr_valid` high is executed at the next rising clock edge. The skip request is a one-cycle pulse in the cycle after the instruction, for the program counter logic to use. A small state machine has the states ST_RUN and ST_HALTED. It takes the transition RUN→HALTED on a group 2 instruction with its halt bit set, and it stays in HALTED until reset. In ST_HALTED every instruction is ignored.

Top module: `opr_unit`

## Requirements
- R1: After reset the accumulator is 0000, link is 0, skip is 0 and halt is 0 (state ST_RUN).
- R2: The unit acts only when `instr_valid` is high and `instr[11:9]` = 3'b111. Any other input leaves accumulator and link unchanged and gives no skip pulse.
- R3: In group 1, `instr[7]` clears the accumulator and `instr[6]` clears the link. Code 7300 octal leaves both at zero.
- R4: In group 1, `instr[5]` complements the accumulator and `instr[4]` complements the link. Both act after the clears.
- R5: In group 1, `instr[0]` adds one to the accumulator after the complements. A carry out of the accumulator (7777→0000) inverts the link. Code 7041 octal gives the two's complement negation.
- R6: In group 1, `instr[3]` rotates right and `instr[2]` rotates left. The rotate acts last, on the 13-bit ring {link, accumulator}, with the link above the accumulator MSB. `instr[1]` makes the rotate two places instead of one. If both rotate bits are set, no rotate takes place.
- R7: A group 2 instruction (`instr[8]`=1, `instr[0]`=0) leaves accumulator and link unchanged. It gives a skip pulse when (`instr[6]` AND accumulator bit 11) XOR `instr[3]` is true. The test uses the accumulator value before the instruction. Code 7510 octal skips when the accumulator is non-negative.
- R8: A group 2 instruction with `instr[1]` set moves the machine to ST_HALTED. `halt` then stays high until reset, and while halted no instruction changes the accumulator or link or gives a skip.
- R9: An operate instruction with `instr[8]`=1 and `instr[0]`=1 has no effect.
- R10: `skip` is high only in the cycle directly after an accepted group 2 instruction whose skip condition held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 12 | Instruction word |
| acc | output | 12 | Accumulator |
| link | output | 1 | Link register |
| skip | output | 1 | One-cycle request to skip the next instruction |
| halt | output | 1 | High while in ST_HALTED |

## Verification
There is no load port, so the unit's own operations are the only way to reach the hard cases: an accumulator of 7777 with the link in a known state for the increment carry, and a negative accumulator for the sign tests. The stimulus reaches 7777 by clearing and then complementing. It builds other patterns by incrementing and by rotating ones through the link. After that, a long pseudo-random run of operate instructions walks through many accumulator and link values, with skip tests mixed in. A halt is issued only at the end, so that the frozen state can then be checked against later instructions.

// File: rtl/opr_pkg.sv
package opr_pkg;

    localparam int WORD_W = 12;

    typedef struct packed {
        logic clr_acc;
        logic clr_lnk;
        logic inv_acc;
        logic inv_lnk;
        logic rot_r;
        logic rot_l;
        logic rot_two;
        logic inc;
    } g1_ctl_t;

    typedef struct packed {
        logic sign_test;
        logic invert;
        logic stop;
    } g2_ctl_t;

    typedef enum logic [0:0] {
        ST_RUN,
        ST_HALTED
    } run_state_t;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import opr_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output logic              is_g1,
    output logic              is_g2,
    output g1_ctl_t           g1,
    output g2_ctl_t           g2
);

    logic is_opr;

    always_comb begin
        is_opr = (instr[WORD_W-1:WORD_W-3] == 3'b111);
        is_g1  = is_opr && !instr[8];
        is_g2  = is_opr && instr[8] && !instr[0];
        g1     = g1_ctl_t'(instr[7:0]);
        g2.sign_test = instr[6];
        g2.invert    = instr[3];
        g2.stop      = instr[1];
    end

endmodule

// File: rtl/opr_group1.sv
module opr_group1
    import opr_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] acc_in,
    input  logic         lnk_in,
    input  g1_ctl_t      ctl,
    output logic [W-1:0] acc_out,
    output logic         lnk_out
);

    localparam int RING_W = W + 1;

    logic [W-1:0]      a_clr, a_inv;
    logic              l_clr, l_inv;
    logic [RING_W-1:0] ring_inc, ring_rot;
    logic [RING_W-1:0] rr1, rr2, rl1, rl2;

    always_comb begin
        a_clr    = ctl.clr_acc ? '0 : acc_in;
        l_clr    = ctl.clr_lnk ? 1'b0 : lnk_in;
        a_inv    = ctl.inv_acc ? ~a_clr : a_clr;
        l_inv    = ctl.inv_lnk ? ~l_clr : l_clr;
        ring_inc = {l_inv, a_inv} + RING_W'(ctl.inc);

        rr1 = {ring_inc[0],        ring_inc[RING_W-1:1]};
        rr2 = {ring_inc[1:0],      ring_inc[RING_W-1:2]};
        rl1 = {ring_inc[RING_W-2:0], ring_inc[RING_W-1]};
        rl2 = {ring_inc[RING_W-3:0], ring_inc[RING_W-1:RING_W-2]};

        unique case ({ctl.rot_r, ctl.rot_l})
            2'b10:   ring_rot = ctl.rot_two ? rr2 : rr1;
            2'b01:   ring_rot = ctl.rot_two ? rl2 : rl1;
            default: ring_rot = ring_inc;
        endcase

        acc_out = ring_rot[W-1:0];
        lnk_out = ring_rot[W];
    end

endmodule

// File: rtl/opr_skip.sv
module opr_skip
    import opr_pkg::*;
(
    input  logic    acc_sign,
    input  g2_ctl_t ctl,
    output logic    skip_req
);

    always_comb begin
        skip_req = (ctl.sign_test && acc_sign) ^ ctl.invert;
    end

endmodule

// File: rtl/opr_unit.sv
module opr_unit
    import opr_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         instr_valid,
    input  logic [11:0]  instr,
    output logic [W-1:0] acc,
    output logic         link,
    output logic         skip,
    output logic         halt
);

    run_state_t state_q, state_d;

    logic    is_g1, is_g2, skip_req, fire;
    g1_ctl_t g1;
    g2_ctl_t g2;
    logic [W-1:0] acc_q, acc_n;
    logic         link_q, link_n, skip_q;

    opr_decode u_decode (
        .instr (instr),
        .is_g1 (is_g1),
        .is_g2 (is_g2),
        .g1    (g1),
        .g2    (g2)
    );

    opr_group1 #(.W(W)) u_group1 (
        .acc_in  (acc_q),
        .lnk_in  (link_q),
        .ctl     (g1),
        .acc_out (acc_n),
        .lnk_out (link_n)
    );

    opr_skip u_skip (
        .acc_sign (acc_q[W-1]),
        .ctl      (g2),
        .skip_req (skip_req)
    );

    assign fire = instr_valid && (state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (fire && is_g2 && g2.stop) state_d = ST_HALTED;
            ST_HALTED: state_d = ST_HALTED;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            link_q <= 1'b0;
            skip_q <= 1'b0;
        end else begin
            skip_q <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    if (fire && is_g1) begin
                        acc_q  <= acc_n;
                        link_q <= link_n;
                    end
                    if (fire && is_g2) skip_q <= skip_req;
                end
                default: begin
                    skip_q <= 1'b0;
                end
            endcase
        end
    end

    assign acc  = acc_q;
    assign link = link_q;
    assign skip = skip_q;
    assign halt = (state_q == ST_HALTED);

endmodule

// File: rtl/opr_unit_chk.sv
module opr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [11:0] instr,
    input logic [11:0] acc,
    input logic        link,
    input logic        skip,
    input logic        halt
);

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(acc) && $stable(link) && !skip);

    assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[11:9] != 3'b111) |=> $stable(acc) && $stable(link) && !skip);

    assert_clear_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !halt && instr == 12'o7300) |=> (acc == 12'o0000) && !link);

    assert_carry_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !halt && instr == 12'o7001 && acc == 12'o7777)
        |=> (acc == 12'o0000) && (link != $past(link)));

    assert_g2_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[11:8] == 4'hF) |=> $stable(acc) && $stable(link));

    assert_skip_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !halt && instr == 12'o7510) |=> (skip == !$past(acc[11])));

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(acc) && $stable(link) && !skip);

    assert_group3_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[11:8] == 4'hF && instr[0]) |=> !skip && !$rose(halt));

    assert_skip_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> $past(instr_valid) && ($past(instr[11:8]) == 4'hF) && !$past(instr[0]));

endmodule

bind opr_unit opr_unit_chk u_opr_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .acc         (acc),
    .link        (link),
    .skip        (skip),
    .halt        (halt)
);

// File: tb/test_opr_unit.sv
`timescale 1ns/1ps
module test_opr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [11:0] instr = 12'o0000;
    logic [11:0] acc;
    logic        link, skip, halt;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    logic [11:0] m_acc = '0;
    logic        m_link = 1'b0;
    logic        m_skip = 1'b0;
    logic        m_halt = 1'b0;

    always #2 clk = ~clk;

    opr_unit i_opr_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .acc         (acc),
        .link        (link),
        .skip        (skip),
        .halt        (halt)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0o expected=%0o", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "acc",  int'(acc),  int'(m_acc));
        check(tag, "link", int'(link), int'(m_link));
        check(tag, "skip", int'(skip), int'(m_skip));
        check(tag, "halt", int'(halt), int'(m_halt));
    endtask

    task automatic model(input logic v, input logic [11:0] ins);
        logic [12:0] ring;
        int          places;
        m_skip = 1'b0;
        if (m_halt || !v || ins[11:9] != 3'b111) return;
        if (!ins[8]) begin
            if (ins[7]) m_acc = 12'o0000;
            if (ins[6]) m_link = 1'b0;
            if (ins[5]) m_acc = 12'o7777 - m_acc;
            if (ins[4]) m_link = !m_link;
            if (ins[0]) begin
                if (m_acc == 12'o7777) begin
                    m_acc = 12'o0000;
                    m_link = !m_link;
                end else begin
                    m_acc = m_acc + 12'd1;
                end
            end
            places = ins[1] ? 2 : 1;
            ring = {m_link, m_acc};
            if (ins[3] && !ins[2])
                for (int k = 0; k < places; k++) ring = (ring >> 1) | (13'(ring[0]) << 12);
            if (ins[2] && !ins[3])
                for (int k = 0; k < places; k++) ring = (ring << 1) | 13'(ring[12]);
            m_link = ring[12];
            m_acc  = ring[11:0];
        end else if (!ins[0]) begin
            m_skip = ((ins[6] && m_acc[11]) != ins[3]);
            if (ins[1]) m_halt = 1'b1;
        end
    endtask

    task automatic step(input logic v, input logic [11:0] ins, input string tag);
        instr_valid = v;
        instr = ins;
        model(v, ins);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #400000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        logic [11:0] ins;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        step(1'b1, 12'o7040, "R4");   // CMA: 0 -> 7777
        step(1'b1, 12'o7001, "R5");   // IAC carry: 0000, link set
        step(1'b1, 12'o7300, "R3");   // clear both
        step(1'b1, 12'o7020, "R4");   // CML
        step(1'b1, 12'o7200, "R3");   // clear acc only
        step(1'b1, 12'o7001, "R5");   // acc 1
        step(1'b1, 12'o7100, "R3");   // clear link
        step(1'b1, 12'o7010, "R6");   // RAR: 1 into link
        step(1'b1, 12'o7004, "R6");   // RAL back
        step(1'b1, 12'o7012, "R6");   // RTR
        step(1'b1, 12'o7006, "R6");   // RTL
        step(1'b1, 12'o7014, "R6");   // both set: no rotate
        step(1'b1, 12'o7041, "R5");   // negate
        step(1'b1, 12'o7510, "R7");   // skip if non-negative (acc negative)
        step(1'b1, 12'o7500, "R7");   // skip if negative
        step(1'b1, 12'o7410, "R7");   // inverted sense alone
        step(1'b1, 12'o7041, "R5");   // negate back to positive
        step(1'b1, 12'o7510, "R10");
        step(1'b1, 12'o7421, "R9");   // group 3: no effect
        step(1'b1, 12'o1234, "R2");   // not an operate code
        step(1'b0, 12'o7040, "R2");   // valid low
        step(1'b1, 12'o7341, "R4");   // clear, complement, increment order
        step(1'b1, 12'o7061, "R5");   // CMA CML IAC

        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ins = 12'o7000 | {3'b000, lf[8:0]};
            if (ins[8]) ins[1] = 1'b0;
            step(1'b1, ins, ins[8] ? "R7" : "R6");
        end

        step(1'b1, 12'o7402, "R8");   // halt
        step(1'b1, 12'o7040, "R8");   // ignored while halted
        step(1'b1, 12'o7410, "R8");
        step(1'b1, 12'o7001, "R8");

        rst_n = 1'b0;
        m_acc = '0; m_link = 1'b0; m_skip = 1'b0; m_halt = 1'b0;
        instr_valid = 1'b0;
        @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        step(1'b1, 12'o7040, "R4");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule